// File: doc/BRIEF.md
# DDR2 Extended Mode Register Programmer

This block writes the extended mode register of a DDR2 memory. A requester offers one configuration on a valid/ready handshake. The configuration covers the DLL on/off choice, the output drive strength, the on-die termination value, the additive latency, the off-chip driver calibration code, the two strobe options and the output disable. The block first checks the fields. A request with a reserved code is refused with a one-cycle error pulse and never reaches the memory. An accepted request is packed into the bank-select and address word of a load-mode command. The block holds that command until the memory controller reports that all banks are idle and no burst is running. It then drives the command for exactly one clock and keeps every further command back for a parameterised tMRD interval.

The handshake is simple. `req_ready` is high only while the block is idle, and a request is taken on a rising edge where both `req_valid` and `req_ready` are high. While the block is busy the requester is back-pressured, and whatever sits on the request pins is ignored. The block keeps its own copy of the fields, so the requester may change them after acceptance. For the calibration step of initialisation, a pair request issues the "load calibration defaults" write and then the "leave calibration" write. The other fields are the same in both writes, and the two commands are spaced by tMRD.

Top module: `ddr2_emr_prog`

## Requirements
- R1: `req_ready` is 1 exactly when `busy` is 0. A request is taken only on an edge with `req_valid` and `req_ready` both high. Request pins seen while `busy` is 1 cause no error and no command.
- R2: A request is refused if its latency code exceeds AL_MAX (default 5), or if it is not a pair request and its calibration code is neither 3'b111 nor 3'b000. A refused request gives `err`=1 for the one cycle after the accepting edge. It never drives `cmd_valid`, and `busy` stays 0.
- R3: An accepted command is driven on the first edge at which `banks_idle`=1 and `burst_active`=0. It is never driven at any other time, and `cmd_valid` lasts exactly one cycle per command.
- R4: During a command, `cmd_ba` is 3'b001 (the extended register select; 000, 010 and 011 select the other mode registers) and address bit 13 is 0.
- R5: Address bit 0 carries `req_dll_off` (1 = DLL off). Bit 1 carries `req_drv_reduced` (1 = reduced drive). Bit 10 carries `req_dqsn_off` (1 = complementary strobe disabled). Bit 11 carries `req_rdqs_on` (1 = read strobe enabled). Bit 12 carries `req_out_off` (1 = outputs off).
- R6: Termination code `req_odt[1:0]` goes to address bits {6,2}, with bit 1 on A6 and bit 0 on A2. The codes are 00 off, 01 75 ohm, 10 150 ohm and 11 50 ohm. `req_al` goes to address bits 5:3.
- R7: For a single request, address bits 9:7 carry `req_ocd` (111 = load calibration defaults, 000 = leave calibration).
- R8: With `req_ocd_pair`=1, `req_ocd` is ignored. Two commands are issued: the first with bits 9:7 = 111 and the second with 000. The second comes exactly TMRD cycles after the first if the banks are idle, or later when they become idle.
- R9: `busy` stays high from acceptance until TMRD cycles after the last command cycle. In that cycle `done` pulses once and `busy` falls. No two commands are closer than TMRD cycles.
- R10: After reset `req_ready`=1, `busy`=0, `cmd_valid`=0, `done`=0, `err`=0. The command bus reads zero whenever `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_dll_off | input | 1 | 1 disables the DLL |
| req_drv_reduced | input | 1 | 1 selects reduced drive |
| req_odt | input | 2 | Termination code |
| req_al | input | 3 | Additive latency code |
| req_ocd | input | 3 | Calibration code for a single write |
| req_ocd_pair | input | 1 | Issue defaults-then-leave pair |
| req_dqsn_off | input | 1 | 1 disables complementary strobe |
| req_rdqs_on | input | 1 | 1 enables read strobe |
| req_out_off | input | 1 | 1 disables outputs |
| banks_idle | input | 1 | All banks idle |
| burst_active | input | 1 | A burst is in progress |
| cmd_valid | output | 1 | Load-mode command this cycle |
| cmd_ba | output | 3 | Bank-select bits of the command |
| cmd_addr | output | ADDR_W | Address bits of the command |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
A refused request shows `err` in the cycle right after the accepting edge. An accepted request with idle banks shows its command one cycle after that, so it appears at the second falling edge after the request was driven. `done` follows TMRD cycles after the last command, and the second write of a pair comes TMRD cycles after the first. The bench drives on falling edges and samples at the falling edge where each result is due. It also checks the cycles in between for the absence of commands, `done` and `err`. Stalls are made by holding `banks_idle` low or `burst_active` high, which moves the due cycle to one cycle after the release.

// File: rtl/ddr2_emr_pkg.sv
package ddr2_emr_pkg;

  localparam int EMR_BITS = 14;

  localparam logic [2:0] BA_EXT1   = 3'b001;
  localparam logic [2:0] OCD_ENTER = 3'b111;
  localparam logic [2:0] OCD_LEAVE = 3'b000;

  typedef struct packed {
    logic       dll_off;
    logic       drv_reduced;
    logic [1:0] odt;
    logic [2:0] al;
    logic [2:0] ocd;
    logic       dqsn_off;
    logic       rdqs_on;
    logic       out_off;
  } emr_cfg_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WAIT,
    SEQ_HOLD
  } seq_state_e;

endpackage

// File: rtl/emr_check.sv
module emr_check
  import ddr2_emr_pkg::*;
#(
  parameter int AL_MAX = 5
) (
  input  logic [2:0] al,
  input  logic [2:0] ocd,
  input  logic       pair,
  output logic       ok
);

  logic al_ok;
  logic ocd_ok;

  generate
    if (AL_MAX >= 7) begin : g_al_all
      assign al_ok = 1'b1;
    end else begin : g_al_lim
      assign al_ok = (int'(al) <= AL_MAX);
    end
  endgenerate

  assign ocd_ok = pair || (ocd == OCD_ENTER) || (ocd == OCD_LEAVE);
  assign ok     = al_ok && ocd_ok;

endmodule

// File: rtl/emr_pack.sv
module emr_pack
  import ddr2_emr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  emr_cfg_t          cfg,
  input  logic              pair,
  input  logic              second,
  output logic [ADDR_W-1:0] addr
);

  logic [2:0]          ocd_sel;
  logic [EMR_BITS-1:0] w;

  assign ocd_sel = pair ? (second ? OCD_LEAVE : OCD_ENTER) : cfg.ocd;

  always_comb begin
    w      = '0;
    w[0]   = cfg.dll_off;
    w[1]   = cfg.drv_reduced;
    w[2]   = cfg.odt[0];
    w[5:3] = cfg.al;
    w[6]   = cfg.odt[1];
    w[9:7] = ocd_sel;
    w[10]  = cfg.dqsn_off;
    w[11]  = cfg.rdqs_on;
    w[12]  = cfg.out_off;
    w[13]  = 1'b0;
  end

  generate
    if (ADDR_W > EMR_BITS) begin : g_pad
      assign addr = {{(ADDR_W-EMR_BITS){1'b0}}, w};
    end else begin : g_exact
      assign addr = w[ADDR_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/emr_seq.sv
module emr_seq
  import ddr2_emr_pkg::*;
#(
  parameter int TMRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_ok,
  input  logic req_pair,
  input  logic banks_idle,
  input  logic burst_active,
  output logic req_ready,
  output logic busy,
  output logic cmd_v,
  output logic pair_o,
  output logic second_o,
  output logic done,
  output logic err
);

  localparam int CW = $clog2(TMRD + 1);
  localparam logic [CW-1:0] LOAD = CW'(TMRD - 1);
  localparam logic [CW-1:0] TOP  = CW'(TMRD);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          pair_r;
  logic          second_r;
  logic          go;

  assign go        = banks_idle && !burst_active;
  assign req_ready = (state == SEQ_IDLE);
  assign busy      = (state != SEQ_IDLE);
  assign pair_o    = pair_r;
  assign second_o  = second_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      cnt      <= '0;
      pair_r   <= 1'b0;
      second_r <= 1'b0;
      cmd_v    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      cmd_v <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (req_valid) begin
            if (req_ok) begin
              state    <= SEQ_WAIT;
              pair_r   <= req_pair;
              second_r <= 1'b0;
            end else begin
              err <= 1'b1;
            end
          end
        end
        SEQ_WAIT: begin
          if (go) begin
            cmd_v <= 1'b1;
            cnt   <= LOAD;
            state <= SEQ_HOLD;
          end
        end
        SEQ_HOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (pair_r && !second_r) begin
            second_r <= 1'b1;
            if (go) begin
              cmd_v <= 1'b1;
              cnt   <= LOAD;
            end else begin
              state <= SEQ_WAIT;
            end
          end else begin
            state <= SEQ_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // cycles since the last command, saturating at TMRD
  logic [CW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap <= TOP;
    else if (cmd_v)      gap <= CW'(1);
    else if (gap != TOP) gap <= gap + CW'(1);
  end

  initial tmrd_param_chk: assert (TMRD >= 1);

  // R3
  cmd_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v |-> $past(go));

  // R9
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v |-> (gap == TOP));

  // R9
  done_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (gap == TOP) && !busy);

  // R2
  err_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !cmd_v && !done);

  // R1
  cmd_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v |-> $past(busy));

  // R3
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v && TMRD > 1) |=> !cmd_v);

endmodule

// File: rtl/ddr2_emr_prog.sv
module ddr2_emr_prog
  import ddr2_emr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int TMRD   = 2,
  parameter int AL_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_dll_off,
  input  logic              req_drv_reduced,
  input  logic [1:0]        req_odt,
  input  logic [2:0]        req_al,
  input  logic [2:0]        req_ocd,
  input  logic              req_ocd_pair,
  input  logic              req_dqsn_off,
  input  logic              req_rdqs_on,
  input  logic              req_out_off,
  input  logic              banks_idle,
  input  logic              burst_active,
  output logic              cmd_valid,
  output logic [2:0]        cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              done,
  output logic              err
);

  emr_cfg_t          cfg_in;
  emr_cfg_t          cfg_q;
  logic              req_ok;
  logic              pair_act;
  logic              second;
  logic [ADDR_W-1:0] word;

  assign cfg_in = '{dll_off: req_dll_off, drv_reduced: req_drv_reduced,
                    odt: req_odt, al: req_al, ocd: req_ocd,
                    dqsn_off: req_dqsn_off, rdqs_on: req_rdqs_on,
                    out_off: req_out_off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cfg_q <= '0;
    else if (req_valid && req_ready) cfg_q <= cfg_in;
  end

  emr_check #(.AL_MAX(AL_MAX)) u_check (
    .al   (req_al),
    .ocd  (req_ocd),
    .pair (req_ocd_pair),
    .ok   (req_ok)
  );

  emr_seq #(.TMRD(TMRD)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ok       (req_ok),
    .req_pair     (req_ocd_pair),
    .banks_idle   (banks_idle),
    .burst_active (burst_active),
    .req_ready    (req_ready),
    .busy         (busy),
    .cmd_v        (cmd_valid),
    .pair_o       (pair_act),
    .second_o     (second),
    .done         (done),
    .err          (err)
  );

  emr_pack #(.ADDR_W(ADDR_W)) u_pack (
    .cfg    (cfg_q),
    .pair   (pair_act),
    .second (second),
    .addr   (word)
  );

  assign cmd_ba   = cmd_valid ? BA_EXT1 : 3'b000;
  assign cmd_addr = cmd_valid ? word : '0;

  // R4
  cmd_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_ba == 3'b001) && !cmd_addr[13]);

  // R7
  cmd_ocd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr[9:7] == 3'b111) || (cmd_addr[9:7] == 3'b000));

  // R1
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready != busy);

endmodule

// File: tb/test_ddr2_emr_prog.sv
module test_ddr2_emr_prog;

  localparam int TMRD   = 2;
  localparam int ADDR_W = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic req_dll_off, req_drv_reduced, req_ocd_pair;
  logic req_dqsn_off, req_rdqs_on, req_out_off;
  logic [1:0] req_odt;
  logic [2:0] req_al, req_ocd;
  logic banks_idle, burst_active;
  logic cmd_valid, busy, done, err;
  logic [2:0] cmd_ba;
  logic [ADDR_W-1:0] cmd_addr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ddr2_emr_prog #(.ADDR_W(ADDR_W), .TMRD(TMRD), .AL_MAX(5)) i_ddr2_emr_prog (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dll_off(req_dll_off), .req_drv_reduced(req_drv_reduced),
    .req_odt(req_odt), .req_al(req_al), .req_ocd(req_ocd),
    .req_ocd_pair(req_ocd_pair), .req_dqsn_off(req_dqsn_off),
    .req_rdqs_on(req_rdqs_on), .req_out_off(req_out_off),
    .banks_idle(banks_idle), .burst_active(burst_active),
    .cmd_valid(cmd_valid), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .busy(busy), .done(done), .err(err)
  );

  // [28]dll [27]drv [26:25]odt [24:22]al [21:19]ocd [18]pair
  // [17]dqsn [16]rdqs [15]out [14]exp_err [13:0]exp_addr
  localparam logic [28:0] VEC [7] = '{
    {1'b0, 1'b0, 2'b00, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000},
    {1'b1, 1'b1, 2'b01, 3'b011, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 14'h041F},
    {1'b0, 1'b0, 2'b10, 3'b101, 3'b111, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 14'h1BE8},
    {1'b0, 1'b0, 2'b11, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0044},
    {1'b0, 1'b0, 2'b00, 3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0000},
    {1'b0, 1'b0, 2'b00, 3'b000, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0000},
    {1'b0, 1'b0, 2'b00, 3'b111, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0000}
  };
  string vtag [7] = '{"R4", "R5", "R7", "R6", "R2", "R2", "R2"};

  task automatic check(input logic cond, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (cond !== 1'b1) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_fields(input logic [28:0] v);
    req_dll_off     = v[28];
    req_drv_reduced = v[27];
    req_odt         = v[26:25];
    req_al          = v[24:22];
    req_ocd         = v[21:19];
    req_ocd_pair    = v[18];
    req_dqsn_off    = v[17];
    req_rdqs_on     = v[16];
    req_out_off     = v[15];
  endtask

  task automatic finish_wait(input string tag);
    for (int k = 0; k < TMRD - 1; k++) begin
      @(negedge clk);
      check(busy && !done && !cmd_valid, tag, {busy, done, cmd_valid}, 3'b100);
    end
    @(negedge clk);
    check(done && !busy && req_ready, tag, {done, busy, req_ready}, 3'b101);
    @(negedge clk);
    check(!done, {tag, " single done"}, done, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; banks_idle = 1'b1; burst_active = 1'b0;
    set_fields('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(req_ready && !busy && !cmd_valid && !done && !err, "R10 reset",
          {req_ready, busy, cmd_valid, done, err}, 5'b10000);
    check(cmd_addr == '0 && cmd_ba == 3'b000, "R10 idle bus", cmd_addr, 0);

    for (int i = 0; i < 7; i++) begin
      logic [28:0] v;
      v = VEC[i];
      set_fields(v);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (v[14]) begin
        check(err && !busy && req_ready, vtag[i], {err, busy, req_ready}, 3'b101);
        check(!cmd_valid, {vtag[i], " no cmd"}, cmd_valid, 0);
        @(negedge clk);
        check(!err && !cmd_valid && !busy, {vtag[i], " quiet"}, {err, cmd_valid, busy}, 0);
      end else begin
        check(busy && !req_ready && !cmd_valid, "R1 busy", {busy, req_ready, cmd_valid}, 3'b100);
        @(negedge clk);
        check(cmd_valid, "R3 issue", cmd_valid, 1);
        check(cmd_addr == v[13:0], vtag[i], cmd_addr, v[13:0]);
        check(cmd_ba == 3'b001 && !cmd_addr[13], "R4 select", cmd_ba, 3'b001);
        finish_wait("R9");
      end
    end

    // R3 hold-off while banks busy; R1 pins ignored while busy
    set_fields('0);
    banks_idle = 1'b0;
    req_valid  = 1'b1;
    @(negedge clk);
    req_al = 3'b111;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!cmd_valid && busy && !req_ready && !err, "R1 R3 stall",
            {cmd_valid, busy, req_ready, err}, 4'b0100);
    end
    req_valid = 1'b0;
    set_fields('0);
    banks_idle = 1'b1; burst_active = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!cmd_valid, "R3 burst", cmd_valid, 0);
    end
    burst_active = 1'b0;
    @(negedge clk);
    check(cmd_valid && cmd_addr == '0, "R3 release", cmd_addr, 0);
    finish_wait("R9 stall");

    // R8 pair with idle banks; req_ocd reserved value ignored
    req_dll_off = 1'b1; req_al = 3'b010; req_ocd = 3'b010; req_ocd_pair = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    set_fields('0);
    check(!err && busy, "R8 pair accepted", {err, busy}, 2'b01);
    @(negedge clk);
    check(cmd_valid && cmd_addr == 14'h0391, "R8 first", cmd_addr, 14'h0391);
    for (int k = 0; k < TMRD - 1; k++) begin
      @(negedge clk);
      check(!cmd_valid && busy, "R8 gap", cmd_valid, 0);
    end
    @(negedge clk);
    check(cmd_valid && cmd_addr == 14'h0011, "R8 second", cmd_addr, 14'h0011);
    finish_wait("R8 done");

    // R8 pair with banks busy between the writes
    req_dll_off = 1'b1; req_al = 3'b010; req_ocd_pair = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    set_fields('0);
    @(negedge clk);
    check(cmd_valid && cmd_addr == 14'h0391, "R8 stall first", cmd_addr, 14'h0391);
    banks_idle = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!cmd_valid && busy && !done, "R8 stall hold", {cmd_valid, busy, done}, 3'b010);
    end
    banks_idle = 1'b1;
    @(negedge clk);
    check(cmd_valid && cmd_addr == 14'h0011, "R8 stall second", cmd_addr, 14'h0011);
    finish_wait("R9 pair");

    summary();
    $finish;
  end

endmodule